// File: doc/BRIEF.md
# Counted-Enable Interrupt Source Controller

This block collects a set of level-sensitive interrupt inputs and turns them into one interrupt request for a processor. Each source is gated by several enable fields spread over a small register bank. A source can raise a request only when every field that refers to it holds a nonzero value. The bank has single-bit mask registers and multi-bit priority registers. Every register can be reached at two bus addresses: one sets bits and the other clears them.

The block does not store each source's enable state directly. It keeps a per-source count that moves only when a written field actually changes value. A source is pending when its input is high and its count equals the number of fields that reference it. The processor reads one aggregate interrupt line. It asks for a vector by presenting its current mask level and gets back the vector of the lowest-numbered pending source.

Top module: `icnt_ctrl`

## Requirements
- R1: After a synchronous reset every register reads zero, no source is pending, `cpu_irq_o` is low and a query returns no vector.
- R2: A write to a register's set address ORs the written bits into the stored value, and a read from either the set or the clear address returns the stored value one cycle later.
- R3: A write to a register's clear address clears each stored bit where the write data holds a one.
- R4: Only bits 28:0 of the bus address are compared, so addresses that differ only in bits 31:29 reach the same register. Mask register m has its set address at BASE + 8m and its clear address at BASE + 8m + 4. The priority registers follow the mask registers in the same layout.
- R5: Fields are numbered from the most significant end. Mask register m, field k is bit (MASK_FIELDS-1-k) and gates source m*MASK_FIELDS+k. Priority register p, field k is bits [(PRIO_FIELDS-1-k)*PRIO_W +: PRIO_W] and gates source p*PRIO_FIELDS+k.
- R6: A source is pending exactly when its input is high and its enable count equals the number of fields that reference it. By default sources 1 to 3 need two fields and sources 4 to 7 need one.
- R7: When a written field changes value, the count of its source rises by one if the new value is nonzero and falls by one if it is zero. A change from one nonzero value to another therefore also raises the count. A field written to its current value leaves the count alone.
- R8: `cpu_irq_o` is high in the cycle after at least one source is pending and low in the cycle after none is.
- R9: A query is answered one cycle later on `q_ack_o`. Mask level 15 gives no vector (`q_hit_o` low, `q_vec_o` zero). Any other level gives the vector VEC_BASE + s*VEC_STEP of the lowest-numbered pending source s, or no vector if none is pending.
- R10: Source 0 is reserved. It never becomes pending, whatever its input or its fields hold, but its register bits are still stored.
- R11: A read from an unmapped address returns zero, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl_i | input | N_SRC | Level of each interrupt source |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| cpu_irq_o | output | 1 | Aggregate interrupt request |
| q_req_i | input | 1 | Vector query strobe |
| q_level_i | input | 4 | Current interrupt mask level of the processor |
| q_ack_o | output | 1 | Query answer valid |
| q_hit_o | output | 1 | A vector is returned |
| q_vec_o | output | VEC_W | Returned vector |

## Verification
The assertions assume that at most one register is decoded per bus access. They also assume that each source is gated by at most one field per register, so one write moves a count by at most one step. The configured addresses and the field-to-source map guarantee both. The counter-stability checks also expect no write to be in flight while the inputs change. The stimulus drives one bus access or one level change at a time, and each is separated by idle cycles. Values are written only through the set and clear aliases, and every value is picked so that the expected count of each source can be followed by hand.

// File: rtl/icnt_pkg.sv
package icnt_pkg;

  // Number of enable fields that gate a source; source 0 is reserved.
  function automatic int refs_of(int src, int mask_regs, int mask_fields,
                                 int prio_regs, int prio_fields);
    int n;
    n = 0;
    if (src != 0) begin
      if (src < mask_regs * mask_fields) n = n + 1;
      if (src < prio_regs * prio_fields) n = n + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/icnt_regbank.sv
module icnt_regbank #(
  parameter int N_SRC       = 8,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int MASK_REGS   = 2,
  parameter int MASK_FIELDS = 4,
  parameter int PRIO_REGS   = 1,
  parameter int PRIO_FIELDS = 4,
  parameter int PRIO_W      = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0408_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [N_SRC-1:0]  inc_o,
  output logic [N_SRC-1:0]  dec_o
);
  localparam int N_REG     = MASK_REGS + PRIO_REGS;
  localparam int PRIO_BITS = PRIO_FIELDS * PRIO_W;
  localparam int REG_W     = (PRIO_BITS > MASK_FIELDS) ? PRIO_BITS : MASK_FIELDS;
  localparam int MATCH_W   = 29;

  logic [REG_W-1:0] reg_q  [N_REG];
  logic [REG_W-1:0] wr_val [N_REG];
  logic [REG_W-1:0] wdat   [N_REG];
  logic [N_REG-1:0] hit_set, hit_clr, wr_en;
  logic [DATA_W-1:0] rd_mux;
  logic unused_bits;

  assign unused_bits = ^{bus_addr_i[ADDR_W-1:MATCH_W], bus_wdata_i[DATA_W-1:REG_W]};

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    localparam int FW = (r < MASK_REGS) ? 1 : PRIO_W;
    localparam int NF = (r < MASK_REGS) ? MASK_FIELDS : PRIO_FIELDS;
    localparam logic [REG_W-1:0] KEEP = {REG_W{1'b1}} >> (REG_W - FW * NF);
    localparam logic [ADDR_W-1:0] SET_A = BASE_ADDR + ADDR_W'(r * 8);
    localparam logic [ADDR_W-1:0] CLR_A = SET_A + ADDR_W'(4);

    assign hit_set[r] = bus_en_i && (bus_addr_i[MATCH_W-1:0] == SET_A[MATCH_W-1:0]);
    assign hit_clr[r] = bus_en_i && (bus_addr_i[MATCH_W-1:0] == CLR_A[MATCH_W-1:0]);
    assign wr_en[r]   = bus_we_i && (hit_set[r] || hit_clr[r]);
    assign wdat[r]    = bus_wdata_i[REG_W-1:0] & KEEP;
    assign wr_val[r]  = hit_set[r] ? (reg_q[r] | wdat[r]) : (reg_q[r] & ~wdat[r]);

    always_ff @(posedge clk) begin
      if (rst)            reg_q[r] <= '0;
      else if (wr_en[r])  reg_q[r] <= wr_val[r];
    end

    assert_set_or_R2: assert property (@(posedge clk) disable iff (rst)
      (bus_we_i && hit_set[r]) |=> ((reg_q[r] & $past(wdat[r])) == $past(wdat[r])));
    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (rst)
      (bus_we_i && hit_clr[r]) |=> ((reg_q[r] & $past(wdat[r])) == '0));
  end

  // Per-source field change detection (one register is decoded per access).
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    if (s == 0) begin : g_rsv
      assign inc_o[s] = 1'b0;
      assign dec_o[s] = 1'b0;
    end else begin : g_map
      logic m_chg, m_new, p_chg, p_new;
      if (s < MASK_REGS * MASK_FIELDS) begin : g_m
        localparam int MR = s / MASK_FIELDS;
        localparam int MB = MASK_FIELDS - 1 - (s % MASK_FIELDS);
        assign m_chg = wr_en[MR] && (reg_q[MR][MB] != wr_val[MR][MB]);
        assign m_new = wr_val[MR][MB];
      end else begin : g_nm
        assign m_chg = 1'b0;
        assign m_new = 1'b0;
      end
      if (s < PRIO_REGS * PRIO_FIELDS) begin : g_p
        localparam int PR = MASK_REGS + s / PRIO_FIELDS;
        localparam int PB = (PRIO_FIELDS - 1 - (s % PRIO_FIELDS)) * PRIO_W;
        assign p_chg = wr_en[PR] && (reg_q[PR][PB +: PRIO_W] != wr_val[PR][PB +: PRIO_W]);
        assign p_new = |wr_val[PR][PB +: PRIO_W];
      end else begin : g_np
        assign p_chg = 1'b0;
        assign p_new = 1'b0;
      end
      assign inc_o[s] = (m_chg && m_new) || (p_chg && p_new);
      assign dec_o[s] = (m_chg && !m_new) || (p_chg && !p_new);
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < N_REG; r++) begin
      if (hit_set[r] || hit_clr[r]) rd_mux = DATA_W'(reg_q[r]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        bus_rdata_o <= '0;
    else if (bus_en_i && !bus_we_i) bus_rdata_o <= rd_mux;
    else                            bus_rdata_o <= '0;
  end

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_en_i && !bus_we_i && !(|hit_set) && !(|hit_clr)) |=> (bus_rdata_o == '0));

endmodule

// File: rtl/icnt_source.sv
module icnt_source #(
  parameter int MAX_EN = 2,
  parameter int CNT_W  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic pend_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             asserted_q;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i && cnt_q != TOP)        cnt_d = cnt_q + 1'b1;
    else if (dec_i && cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      asserted_q <= 1'b0;
      pend_o     <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (lvl_i != asserted_q) asserted_q <= lvl_i;
      pend_o <= lvl_i && (cnt_d == CNT_W'(MAX_EN));
    end
  end

  assert_pend_rule_R6: assert property (@(posedge clk) disable iff (rst)
    pend_o |-> (asserted_q && cnt_q == CNT_W'(MAX_EN)));
  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !dec_i) |=> $stable(cnt_q));

endmodule

// File: rtl/icnt_vector.sv
module icnt_vector #(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 12,
  parameter int VEC_BASE = 'h200,
  parameter int VEC_STEP = 'h20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pend_i,
  input  logic             q_req_i,
  input  logic [3:0]       q_level_i,
  output logic             q_ack_o,
  output logic             q_hit_o,
  output logic [VEC_W-1:0] q_vec_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             found;
  logic [IDX_W-1:0] idx;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int s = N_SRC - 1; s >= 0; s--) begin
      if (pend_i[s]) begin
        found = 1'b1;
        idx   = IDX_W'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_ack_o <= 1'b0;
      q_hit_o <= 1'b0;
      q_vec_o <= '0;
    end else begin
      q_ack_o <= q_req_i;
      if (q_req_i && found && q_level_i != 4'hF) begin
        q_hit_o <= 1'b1;
        q_vec_o <= VEC_W'(VEC_BASE + int'(idx) * VEC_STEP);
      end else begin
        q_hit_o <= 1'b0;
        q_vec_o <= '0;
      end
    end
  end

  assert_mask15_none_R9: assert property (@(posedge clk) disable iff (rst)
    (q_req_i && q_level_i == 4'hF) |=> (q_ack_o && !q_hit_o));
  assert_empty_none_R9: assert property (@(posedge clk) disable iff (rst)
    (q_req_i && pend_i == '0) |=> !q_hit_o);

endmodule

// File: rtl/icnt_ctrl.sv
module icnt_ctrl #(
  parameter int N_SRC       = 8,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int MASK_REGS   = 2,
  parameter int MASK_FIELDS = 4,
  parameter int PRIO_REGS   = 1,
  parameter int PRIO_FIELDS = 4,
  parameter int PRIO_W      = 4,
  parameter int CNT_W       = 3,
  parameter int VEC_W       = 12,
  parameter int VEC_BASE    = 'h200,
  parameter int VEC_STEP    = 'h20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0408_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_lvl_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              cpu_irq_o,
  input  logic              q_req_i,
  input  logic [3:0]        q_level_i,
  output logic              q_ack_o,
  output logic              q_hit_o,
  output logic [VEC_W-1:0]  q_vec_o
);
  import icnt_pkg::*;

  logic [N_SRC-1:0] inc, dec, pend;
  logic unused_src0;

  assign unused_src0 = ^{inc[0], dec[0], src_lvl_i[0]};

  icnt_regbank #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MASK_REGS(MASK_REGS), .MASK_FIELDS(MASK_FIELDS),
    .PRIO_REGS(PRIO_REGS), .PRIO_FIELDS(PRIO_FIELDS), .PRIO_W(PRIO_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_bank (
    .clk(clk), .rst(rst),
    .bus_en_i(bus_en_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .inc_o(inc), .dec_o(dec)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    if (s == 0) begin : g_rsv
      assign pend[s] = 1'b0;
    end else begin : g_live
      icnt_source #(
        .MAX_EN(refs_of(s, MASK_REGS, MASK_FIELDS, PRIO_REGS, PRIO_FIELDS)),
        .CNT_W(CNT_W)
      ) u_src (
        .clk(clk), .rst(rst),
        .lvl_i(src_lvl_i[s]), .inc_i(inc[s]), .dec_i(dec[s]),
        .pend_o(pend[s])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_irq_o <= 1'b0;
    else     cpu_irq_o <= (pend != '0);
  end

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (rst)
    (pend != '0) |=> cpu_irq_o);
  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> !cpu_irq_o);

  icnt_vector #(
    .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_vec (
    .clk(clk), .rst(rst), .pend_i(pend),
    .q_req_i(q_req_i), .q_level_i(q_level_i),
    .q_ack_o(q_ack_o), .q_hit_o(q_hit_o), .q_vec_o(q_vec_o)
  );

endmodule

// File: tb/test_icnt_ctrl.sv
`timescale 1ns/1ps
module test_icnt_ctrl;
  localparam int N_SRC = 8;
  localparam logic [31:0] M0S = 32'h0408_0000, M0C = 32'h0408_0004;
  localparam logic [31:0] M1S = 32'h0408_0008, M1C = 32'h0408_000C;
  localparam logic [31:0] PS  = 32'h0408_0010, PC  = 32'h0408_0014;
  localparam logic [31:0] UNM = 32'h0408_0040;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_SRC-1:0] src_lvl = '0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic cpu_irq, q_req = 1'b0, q_ack, q_hit;
  logic [3:0] q_level = '0;
  logic [11:0] q_vec;

  int checks = 0;
  int failures = 0;
  logic        exp_hit_q [$];
  logic [11:0] exp_vec_q [$];
  string       exp_tag_q [$];

  always #4 clk = ~clk;

  icnt_ctrl i_icnt_ctrl (
    .clk(clk), .rst(rst), .src_lvl_i(src_lvl),
    .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .cpu_irq_o(cpu_irq),
    .q_req_i(q_req), .q_level_i(q_level), .q_ack_o(q_ack),
    .q_hit_o(q_hit), .q_vec_o(q_vec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bread(input string tag, input logic [31:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  // Driver: pushes the expected answer, then issues the query.
  task automatic query(input string tag, input logic [3:0] lvl,
                       input logic hit, input logic [11:0] vec);
    @(negedge clk);
    exp_hit_q.push_back(hit); exp_vec_q.push_back(vec); exp_tag_q.push_back(tag);
    q_req = 1'b1; q_level = lvl;
    @(negedge clk);
    q_req = 1'b0;
    idle(1);
  endtask

  // Monitor: compares each answer against the scoreboard.
  always @(negedge clk) begin
    if (q_ack) begin
      if (exp_hit_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R9 unexpected answer actual=0x%0h expected=none", q_vec);
      end else begin
        string t;
        logic eh;
        logic [11:0] ev;
        t = exp_tag_q.pop_front(); eh = exp_hit_q.pop_front(); ev = exp_vec_q.pop_front();
        check({t, " hit"}, 32'(q_hit), 32'(eh));
        check({t, " vec"}, 32'(q_vec), 32'(ev));
      end
    end
  end

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 irq after reset", 32'(cpu_irq), 0);
    bread("R1 mask0 after reset", M0S, 0);
    bread("R1 prio after reset", PC, 0);
    query("R1 no vector after reset", 4'd0, 1'b0, 12'h0);

    // R2/R5/R6: source 4 gated by mask1 bit3 only
    bwrite(M1S, 32'h8);
    bread("R2 read via clear alias", M1C, 32'h8);
    src_lvl[4] = 1'b1;
    idle(3);
    check("R8 irq with src4 pending", 32'(cpu_irq), 1);
    query("R6 src4 vector", 4'd3, 1'b1, 12'h280);
    query("R9 mask level 15", 4'hF, 1'b0, 12'h0);

    // R6: source 1 needs mask0 bit2 and prio field1
    bwrite(M0S, 32'h4);
    src_lvl[1] = 1'b1;
    idle(2);
    query("R6 src1 one of two", 4'd0, 1'b1, 12'h280);
    bwrite(PS, 32'h0100);
    idle(1);
    query("R5 R9 src1 lowest", 4'd0, 1'b1, 12'h220);

    // R7: nonzero to nonzero change raises the count past the limit
    bwrite(PS, 32'h0200);
    idle(1);
    query("R7 src1 overcounted", 4'd0, 1'b1, 12'h280);
    bread("R2 prio OR", PS, 32'h0300);
    bwrite(PC, 32'h0300);
    idle(1);
    bread("R3 prio cleared", PS, 32'h0);
    query("R7 src1 back to limit", 4'd0, 1'b1, 12'h220);
    bwrite(M0C, 32'h4);
    idle(1);
    query("R7 src1 mask cleared", 4'd0, 1'b1, 12'h280);
    bwrite(M1S, 32'h8);
    idle(1);
    query("R7 unchanged field", 4'd0, 1'b1, 12'h280);

    // R4: upper address bits ignored
    bwrite(32'hE408_0008, 32'h1);
    bread("R4 alias read", 32'hA408_000C, 32'h9);

    // R8: falls when nothing pending
    src_lvl[4] = 1'b0;
    idle(3);
    check("R8 irq low", 32'(cpu_irq), 0);
    query("R9 nothing pending", 4'd0, 1'b0, 12'h0);

    // R10: reserved source
    bwrite(M0S, 32'h8);
    bwrite(PS, 32'hF000);
    src_lvl[0] = 1'b1;
    idle(3);
    check("R10 irq stays low", 32'(cpu_irq), 0);
    query("R10 no vector", 4'd0, 1'b0, 12'h0);
    bread("R10 bits stored", M0S, 32'h8);

    // R11: unmapped address
    bwrite(UNM, 32'hFFFF);
    bread("R11 unmapped read", UNM, 32'h0);
    bread("R11 mask0 untouched", M0C, 32'h8);
    bread("R11 prio untouched", PS, 32'hF000);

    // R5: last field positions
    src_lvl[7] = 1'b1;
    idle(3);
    check("R8 irq src7", 32'(cpu_irq), 1);
    query("R5 src7 mask bit0", 4'd0, 1'b1, 12'h2E0);
    bwrite(M0S, 32'h1);
    bwrite(PS, 32'h0002);
    src_lvl[3] = 1'b1;
    idle(2);
    query("R5 src3 lowest", 4'd2, 1'b1, 12'h260);
    bwrite(M1C, 32'hF);
    src_lvl[3] = 1'b0;
    idle(3);
    check("R3 R8 all cleared irq", 32'(cpu_irq), 0);
    bread("R3 mask1 cleared", M1S, 32'h0);

    idle(2);
    check("R9 scoreboard drained", 32'(exp_hit_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule